// File: doc/BRIEF.md
# Sparse-Select Flash Thermometer Encoder with Code Remap

This block sits behind the comparator bank of a flash converter in which many comparators exist but only a calibrated subset is used. An enable mask picks which comparators take part. Every comparator left out of the mask has its power-down line driven high. For each sampled comparator word, the block considers only the enabled comparators, which are taken to have thresholds that rise with their index. It finds where their outputs change from 1 to 0 and reduces that point to a single asserted line. That line is encoded into a binary comparator index.

The index is not the final result. It addresses a writable table whose entries hold the calibrated voltage code for each comparator. A host loads this table, and the mask, through a simple write port after foreground calibration. A new sample enters on a valid strobe. The remapped code appears on a registered output with a matching valid pulse. Host writes that arrive while a conversion is being processed are dropped, so a result is never formed from a half-updated table or mask.

Top module: `flash_lut_enc`

## Requirements
- R1: After reset, `code_o` is 0, `code_vld_o` is 0, every mask bit is 1 (so `pwr_dn_o` is all zeros) and every table entry is 0.
- R2: A write with `wr_tgt_i` = 1 sets mask bit `wr_addr_i` to `wr_data_i[0]`. From the next clock edge on, `pwr_dn_o[i]` is the inverse of mask bit i.
- R3: A write with `wr_tgt_i` = 0 stores `wr_data_i` in table entry `wr_addr_i`. Later conversions that resolve to that index return the new value.
- R4: Comparator i qualifies when it is enabled, reads 1, and the nearest enabled comparator above it reads 0 (or no enabled comparator lies above it). The output code is the table entry of the qualifying index. Outputs of disabled comparators have no effect.
- R5: When a word with bubbles has several qualifying comparators, the one with the lowest index decides the code.
- R6: When no enabled comparator reads 1 (including the case where none is enabled), the output code is 0 and the table is not consulted.
- R7: When every enabled comparator reads 1, the output code is the table entry of the highest enabled comparator (full scale).
- R8: A sample taken at a clock edge with `smp_vld_i` high gives `code_vld_o` high for exactly one cycle, two edges later. `code_o` keeps its value when no result is delivered.
- R9: A host write (mask or table) is ignored in any cycle where `smp_vld_i` is high or a sample is held in the first pipeline stage.
- R10: The transition logic presents at most one asserted line to the binary encoder in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_i | input | N_CMP | Raw comparator outputs, bit i from comparator i |
| smp_vld_i | input | 1 | Sample strobe for `cmp_i` |
| wr_en_i | input | 1 | Host write enable |
| wr_tgt_i | input | 1 | Write target: 0 = table, 1 = mask |
| wr_addr_i | input | IDX_W | Comparator index for the write |
| wr_data_i | input | CODE_W | Table code, or mask bit in bit 0 |
| pwr_dn_o | output | N_CMP | Power-down control per comparator (1 = off) |
| code_o | output | CODE_W | Remapped voltage code |
| code_vld_o | output | 1 | Pulse marking a new `code_o` |

## Verification
A conversion passes through two registers. The index is captured on the edge that sees the strobe, and the table read is registered on the following edge. The bench therefore drives a sample on a falling edge, releases the strobe on the next falling edge, and reads `code_o` on the falling edge after the second rising edge. One directed sequence samples the valid line on each falling edge in turn, to confirm it is low, then high, then low again. Writes take effect on the single rising edge after they are driven, so mask effects on `pwr_dn_o` are checked at the very next falling edge. Writes that must be dropped are issued in the strobe cycle and in the in-flight cycle, then checked through `pwr_dn_o` and through the code returned by a following conversion.

// File: rtl/flash_lut_pkg.sv
package flash_lut_pkg;

    // Host write target selector
    typedef enum logic {
        WR_TABLE = 1'b0,
        WR_MASK  = 1'b1
    } wr_tgt_e;

endpackage

// File: rtl/flash_xing_detect.sv
// Finds the 1-to-0 transition among enabled comparators and returns a
// one-hot vector holding only the lowest qualifying point.
module flash_xing_detect #(
    parameter int N_CMP = 16
) (
    input  logic [N_CMP-1:0] cmp_i,
    input  logic [N_CMP-1:0] en_i,
    output logic [N_CMP-1:0] onehot_o
);

    logic [N_CMP-1:0] above_d;   // value of the nearest enabled comparator above i
    logic [N_CMP-1:0] hit_d;

    always_comb begin
        logic carry;
        carry   = 1'b0;          // nothing enabled above the top reads as 0
        above_d = '0;
        for (int i = N_CMP - 1; i >= 0; i--) begin
            above_d[i] = carry;
            if (en_i[i]) begin
                carry = cmp_i[i];
            end
        end
    end

    always_comb begin
        hit_d    = en_i & cmp_i & ~above_d;
        // keep the lowest qualifying transition only
        onehot_o = hit_d & (~hit_d + {{(N_CMP-1){1'b0}}, 1'b1});
    end

endmodule

// File: rtl/flash_onehot_enc.sv
// OR-tree encoder from a one-hot line vector to a binary index.
module flash_onehot_enc #(
    parameter int N_CMP = 16,
    parameter int IDX_W = $clog2(N_CMP)
) (
    input  logic [N_CMP-1:0] onehot_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        always_comb begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i < N_CMP; i++) begin
                if (((i >> b) & 1) == 1) begin
                    acc = acc | onehot_i[i];
                end
            end
            idx_o[b] = acc;
        end
    end

    assign any_o = |onehot_i;

endmodule

// File: rtl/flash_code_lut.sv
// Writable per-comparator code table with an asynchronous read port.
module flash_code_lut #(
    parameter int N_CMP  = 16,
    parameter int CODE_W = 8,
    parameter int IDX_W  = $clog2(N_CMP)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [CODE_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [CODE_W-1:0] rdata_o
);

    typedef logic [CODE_W-1:0] entry_t;

    entry_t tbl_d [N_CMP];
    entry_t tbl_q [N_CMP];

    always_comb begin
        tbl_d = tbl_q;
        if (we_i && (int'(waddr_i) < N_CMP)) begin
            tbl_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < N_CMP; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rdata_o = (int'(raddr_i) < N_CMP) ? tbl_q[raddr_i] : '0;

endmodule

// File: rtl/flash_lut_enc.sv
module flash_lut_enc #(
    parameter int N_CMP  = 16,
    parameter int CODE_W = 8,
    localparam int IDX_W = $clog2(N_CMP)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_CMP-1:0]  cmp_i,
    input  logic              smp_vld_i,
    input  logic              wr_en_i,
    input  logic              wr_tgt_i,
    input  logic [IDX_W-1:0]  wr_addr_i,
    input  logic [CODE_W-1:0] wr_data_i,
    output logic [N_CMP-1:0]  pwr_dn_o,
    output logic [CODE_W-1:0] code_o,
    output logic              code_vld_o
);

    import flash_lut_pkg::*;

    typedef struct packed {
        logic [N_CMP-1:0]  mask;
        logic              s1_vld;
        logic              s1_hit;
        logic [IDX_W-1:0]  s1_idx;
        logic              out_vld;
        logic [CODE_W-1:0] code;
    } state_t;

    state_t st_d, st_q;

    logic [N_CMP-1:0]  onehot_w;
    logic [IDX_W-1:0]  idx_w;
    logic              any_w;
    logic [CODE_W-1:0] lut_rd_w;
    logic              busy_w;
    logic              wr_ok_w;
    logic              lut_we_w;
    logic              s1_vld_w;
    logic              s1_hit_w;

    flash_xing_detect #(.N_CMP(N_CMP)) u_xing (
        .cmp_i    (cmp_i),
        .en_i     (st_q.mask),
        .onehot_o (onehot_w)
    );

    flash_onehot_enc #(.N_CMP(N_CMP), .IDX_W(IDX_W)) u_enc (
        .onehot_i (onehot_w),
        .idx_o    (idx_w),
        .any_o    (any_w)
    );

    flash_code_lut #(.N_CMP(N_CMP), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_lut (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (lut_we_w),
        .waddr_i (wr_addr_i),
        .wdata_i (wr_data_i),
        .raddr_i (st_q.s1_idx),
        .rdata_o (lut_rd_w)
    );

    // a conversion is in flight from the strobe cycle until the table read
    assign busy_w   = smp_vld_i | st_q.s1_vld;
    assign wr_ok_w  = wr_en_i & ~busy_w;
    assign lut_we_w = wr_ok_w & (wr_tgt_e'(wr_tgt_i) == WR_TABLE);

    always_comb begin
        st_d = st_q;

        if (wr_ok_w && (wr_tgt_e'(wr_tgt_i) == WR_MASK) && (int'(wr_addr_i) < N_CMP)) begin
            st_d.mask[wr_addr_i] = wr_data_i[0];
        end

        // stage 1: transition index
        st_d.s1_vld = smp_vld_i;
        if (smp_vld_i) begin
            st_d.s1_hit = any_w;
            st_d.s1_idx = idx_w;
        end

        // stage 2: remapped code
        st_d.out_vld = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.code = st_q.s1_hit ? lut_rd_w : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_dn_o   = ~st_q.mask;
    assign code_o     = st_q.code;
    assign code_vld_o = st_q.out_vld;
    assign s1_vld_w   = st_q.s1_vld;
    assign s1_hit_w   = st_q.s1_hit;

endmodule

// File: rtl/flash_lut_enc_chk.sv
module flash_lut_enc_chk #(
    parameter int N_CMP  = 16,
    parameter int CODE_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              smp_vld_i,
    input logic              wr_en_i,
    input logic              wr_tgt_i,
    input logic [N_CMP-1:0]  onehot_w,
    input logic              s1_vld_w,
    input logic              s1_hit_w,
    input logic [N_CMP-1:0]  pwr_dn_o,
    input logic [CODE_W-1:0] code_o,
    input logic              code_vld_o
);

    // R10
    single_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(onehot_w));

    // R8
    result_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_vld_i |-> ##2 code_vld_o);

    // R8
    code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s1_vld_w |=> $stable(code_o));

    // R9
    mask_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_tgt_i && (smp_vld_i || s1_vld_w)) |=> $stable(pwr_dn_o));

    // R6
    empty_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s1_vld_w && !s1_hit_w) |=> (code_o == '0));

endmodule

bind flash_lut_enc flash_lut_enc_chk #(.N_CMP(N_CMP), .CODE_W(CODE_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_vld_i  (smp_vld_i),
    .wr_en_i    (wr_en_i),
    .wr_tgt_i   (wr_tgt_i),
    .onehot_w   (onehot_w),
    .s1_vld_w   (s1_vld_w),
    .s1_hit_w   (s1_hit_w),
    .pwr_dn_o   (pwr_dn_o),
    .code_o     (code_o),
    .code_vld_o (code_vld_o)
);

// File: tb/flash_lut_enc_tb.sv
`timescale 1ns/1ps
module flash_lut_enc_tb;

    localparam int N = 16;
    localparam int CW = 8;
    localparam logic [N-1:0] MASK0 = 16'hB6D5;  // enabled: 0,2,4,6,7,9,10,12,13,15
    localparam int NV = 9;
    localparam logic [N-1:0] VCMP [NV] = '{
        16'h0000, 16'hFFFF, 16'h00FF, 16'h003F, 16'h49FF,
        16'h00C5, 16'h4902, 16'h7FFF, 16'h0001
    };
    // expected qualifying index, -1 for code 0
    localparam int VIDX [NV] = '{-1, 15, 7, 4, 7, 2, -1, 13, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  cmp = '0;
    logic          smp = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_tgt = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [N-1:0]  pwr_dn;
    logic [CW-1:0] code;
    logic          code_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_lut_enc #(.N_CMP(N), .CODE_W(CW)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cmp_i      (cmp),
        .smp_vld_i  (smp),
        .wr_en_i    (wr_en),
        .wr_tgt_i   (wr_tgt),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .pwr_dn_o   (pwr_dn),
        .code_o     (code),
        .code_vld_o (code_vld)
    );

    function automatic logic [CW-1:0] lutv(input int i);
        return CW'(i * 13 + 5);
    endfunction

    function automatic string vreq(input int k);
        case (k)
            0:       return "R6 all-zero";
            1:       return "R7 all-one";
            4:       return "R4 disabled ignored";
            5:       return "R5 bubble";
            6:       return "R6 only disabled high";
            default: return "R4 transition";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic tgt, input int a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_tgt = tgt; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // ends on the falling edge after the result register loads
    task automatic conv(input logic [N-1:0] c);
        @(negedge clk);
        cmp = c; smp = 1'b1;
        @(negedge clk);
        smp = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(code == '0, "R1 code", 32'(code), 0);
        check(code_vld == 1'b0, "R1 valid", 32'(code_vld), 0);
        check(pwr_dn == '0, "R1 power-down", 32'(pwr_dn), 0);
        conv(16'h0001);  // table still zero after reset
        check(code == '0, "R1 table reset", 32'(code), 0);

        for (int i = 0; i < N; i++) wr(1'b0, i, lutv(i));
        for (int i = 0; i < N; i++) wr(1'b1, i, {7'b0, MASK0[i]});
        @(negedge clk);
        // R2
        check(pwr_dn == ~MASK0, "R2 mask load", 32'(pwr_dn), 32'(~MASK0));

        for (int k = 0; k < NV; k++) begin
            logic [CW-1:0] exp;
            conv(VCMP[k]);
            exp = (VIDX[k] < 0) ? '0 : lutv(VIDX[k]);
            check(code_vld && code == exp, vreq(k), 32'(code), 32'(exp));
        end

        // R8: valid pulse timing and hold
        @(negedge clk);
        cmp = 16'h003F; smp = 1'b1;
        @(negedge clk);
        smp = 1'b0;
        check(code_vld == 1'b0, "R8 not yet valid", 32'(code_vld), 0);
        @(negedge clk);
        check(code_vld == 1'b1 && code == lutv(4), "R8 due", 32'(code), 32'(lutv(4)));
        cmp = 16'hFFFF;
        @(negedge clk);
        check(code_vld == 1'b0 && code == lutv(4), "R8 single pulse and hold", 32'(code), 32'(lutv(4)));

        // R9: writes in strobe cycle and in-flight cycle are dropped
        @(negedge clk);
        cmp = 16'h00FF; smp = 1'b1;
        wr_en = 1'b1; wr_tgt = 1'b0; wr_addr = 4'd7; wr_data = 8'hEE;
        @(negedge clk);
        smp = 1'b0;
        wr_tgt = 1'b1; wr_addr = 4'd6; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        check(code == lutv(7), "R9 table write dropped", 32'(code), 32'(lutv(7)));
        check(pwr_dn == ~MASK0, "R9 mask write dropped", 32'(pwr_dn), 32'(~MASK0));
        conv(16'h00FF);
        check(code == lutv(7), "R9 table unchanged", 32'(code), 32'(lutv(7)));

        // R3
        wr(1'b0, 7, 8'hAA);
        conv(16'h00FF);
        check(code == 8'hAA, "R3 table rewrite", 32'(code), 32'hAA);

        // R2 then R7 with a new top enabled comparator
        wr(1'b1, 15, 8'h00);
        @(negedge clk);
        check(pwr_dn[15] == 1'b1, "R2 disable bit 15", 32'(pwr_dn), 32'(~(MASK0 & 16'h7FFF)));
        conv(16'hFFFF);
        check(code == lutv(13), "R7 full scale after mask change", 32'(code), 32'(lutv(13)));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule